// File: doc/BRIEF.md
# Type 1 Bridge Header Emulation Shim

This block sits on the configuration-access path in front of a root-port function. That function implements a Type 0 configuration header. The shim makes the function appear as a compliant PCI-to-PCI bridge (Type 1 header) at device 0, function 0 of its primary bus. Each request carries a bus, device, function, byte offset, access size and write data.

The shim settles every request in one of three ways:
- It serves the request locally from a small shadow register file.
- It drops the request and answers with all ones.
- It forwards the request to the hardware function.

Forwarded accesses to the bridge itself are re-addressed. The hardware keeps the bridge at device 1 on the secondary bus number. Read data returned from the hardware is patched on the way back so that the header-layout field and the class code describe a bridge. Writes to the bus-number bytes are captured, and the block drives the primary and secondary bus numbers as outputs. The secondary number doubles as the local bus number of the port.

Read data is registered and appears one cycle after the request. Forwarded requests are presented combinationally, and the hardware answers within the same cycle on `fwd_rdata`.

Top module: `t1_bridge_shim`

## Requirements
- R1: An access whose bus equals the primary bus number, with device 0, function 0 and offset in 0x010..0x033 or 0x038..0x03B, is served from the shadow file and never asserts `fwd_valid`. Any offset with a nonzero bit above bit 7 is outside the window.
- R2: A write to the shadow dwords at 0x10, 0x14 or 0x38 stores zero whatever the data, so a later read of these dwords returns zero.
- R3: `req_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit, and offset bits 1:0 select the lane. A shadow write changes only the addressed bytes. A read returns the addressed lane right-justified, with the upper bits zero.
- R4: For the bridge, a forwarded read of dword 0x0C returns the hardware data with bits 22:16 forced to 0x01. Bit 23 and all other bits are passed through unchanged.
- R5: For the bridge, a forwarded read of dword 0x08 returns bits 31:8 as 0x060400. Bits 7:0 come from the hardware.
- R6: A shadow write covering byte 0x18 (a byte write at offset 0x18, or any wider write starting there) loads `pri_bus` from that byte. This moves the bridge's bus.
- R7: A shadow write covering byte 0x19 (a byte write at 0x19, or a 16/32-bit write at 0x18) loads `sec_bus` from that byte. Writes to 0x1A or 0x1B leave both bus numbers unchanged.
- R8: After reset, both bus numbers are 0. Shadow dword 0x1C reads 0x00000101 (32-bit I/O decode code in base and limit). Shadow dword 0x24 reads 0x00010001 (64-bit prefetchable decode code in base and limit). All other shadow dwords read 0.
- R9: A non-shadowed access to the bridge is forwarded with bus = `sec_bus`, device 1, function 0 and the same dword offset.
- R10: An access on the primary bus to any device or function other than 0/0 is not forwarded. Its read returns all ones over the access width.
- R11: An access on any other bus is forwarded with unchanged bus, device and function. `fwd_offset` is the dword-aligned offset. `fwd_be` holds the lane enables, and `fwd_wdata` holds the write data shifted into its lane.
- R12: `rsp_valid` pulses for exactly one cycle, one cycle after each read request, and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | DEV_W | Target device number |
| req_func | input | FN_W | Target function number |
| req_offset | input | OFF_W | Byte offset in configuration space |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-justified lane |
| fwd_valid | output | 1 | Pass-through request to hardware |
| fwd_write | output | 1 | Pass-through direction |
| fwd_bus | output | BUS_W | Pass-through bus number |
| fwd_dev | output | DEV_W | Pass-through device number |
| fwd_func | output | FN_W | Pass-through function number |
| fwd_offset | output | OFF_W | Dword-aligned pass-through offset |
| fwd_be | output | 4 | Pass-through byte enables |
| fwd_wdata | output | 32 | Pass-through lane-aligned write data |
| fwd_rdata | input | 32 | Hardware dword read data, same cycle |
| pri_bus | output | BUS_W | Current primary bus number |
| sec_bus | output | BUS_W | Current secondary (local) bus number |

## Verification
The assertions take two things for granted:
- Every request has a legal size code, and its offset is aligned to that size.
- The hardware answers a forwarded read in the same cycle.

The stimulus keeps within these limits:
- It issues only sizes 0 to 2, with 16-bit accesses at even offsets and 32-bit accesses at multiples of four.
- It models the hardware as a pure function of the forwarded bus, device, function and dword, so every read has an answer before the clock edge.
- It leaves an idle cycle after each request, so every response is seen on its own.

The sweeps cover:
- every shadow dword;
- every lane of the byte-merged dwords;
- every device and function pair on the primary bus;
- every device on several other buses.

// File: rtl/t1_shim_pkg.sv
package t1_shim_pkg;

   localparam int DWORD_W = 32;
   localparam int LANES   = DWORD_W / 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      SRC_HW     = 2'd0,
      SRC_SHADOW = 2'd1,
      SRC_FLOAT  = 2'd2
   } rd_src_e;

   function automatic logic [LANES-1:0] lane_enables(input logic [1:0] sz,
                                                     input logic [1:0] ofs);
      case (sz)
         2'd0:    return 4'b0001 << ofs;
         2'd1:    return ofs[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [DWORD_W-1:0] lane_place(input logic [DWORD_W-1:0] d,
                                                     input logic [1:0] sz,
                                                     input logic [1:0] ofs);
      case (sz)
         2'd0:    return {24'd0, d[7:0]} << {ofs, 3'b000};
         2'd1:    return {16'd0, d[15:0]} << {ofs[1], 4'b0000};
         default: return d;
      endcase
   endfunction

   function automatic logic [DWORD_W-1:0] lane_pick(input logic [DWORD_W-1:0] d,
                                                    input logic [1:0] sz,
                                                    input logic [1:0] ofs);
      logic [DWORD_W-1:0] t;
      case (sz)
         2'd0: begin
            t = d >> {ofs, 3'b000};
            return {24'd0, t[7:0]};
         end
         2'd1: begin
            t = d >> {ofs[1], 4'b0000};
            return {16'd0, t[15:0]};
         end
         default: return d;
      endcase
   endfunction

   function automatic logic [DWORD_W-1:0] lane_merge(input logic [DWORD_W-1:0] old_d,
                                                     input logic [DWORD_W-1:0] new_d,
                                                     input logic [LANES-1:0]   be);
      logic [DWORD_W-1:0] r;
      for (int i = 0; i < LANES; i++)
         r[i*8 +: 8] = be[i] ? new_d[i*8 +: 8] : old_d[i*8 +: 8];
      return r;
   endfunction

endpackage

// File: rtl/t1_shim_decode.sv
module t1_shim_decode #(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 4,
   parameter int WIN_LO = 'h10,
   parameter int WIN_HI = 'h33,
   parameter int ROM_LO = 'h38,
   parameter int ROM_HI = 'h3B,
   parameter int HDR_DW = 3,
   parameter int CLS_DW = 2
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic [FN_W-1:0]  fn,
   input  logic [OFF_W-1:0] off,
   input  logic [BUS_W-1:0] pri,
   output logic             on_bridge,
   output logic             blocked,
   output logic             shadow_hit,
   output logic [IDX_W-1:0] shadow_idx,
   output logic             hdr_dw,
   output logic             cls_dw
);

   localparam int DWA_W = OFF_W - 2;

   initial begin
      assert (IDX_W + 2 <= OFF_W) else $error("offset too narrow for shadow index");
      assert (ROM_HI < (1 << OFF_W)) else $error("window beyond offset range");
   end

   logic             on_primary;
   logic             root_fn;
   logic             in_win;
   logic             in_rom;
   logic [OFF_W-1:0] rel;
   logic [DWA_W-1:0] dwa;

   assign on_primary = (bus == pri);
   assign root_fn    = (dev == '0) && (fn == '0);
   assign on_bridge  = on_primary && root_fn;
   assign blocked    = on_primary && !root_fn;

   assign in_win = (off >= OFF_W'(WIN_LO)) && (off <= OFF_W'(WIN_HI));
   assign in_rom = (off >= OFF_W'(ROM_LO)) && (off <= OFF_W'(ROM_HI));

   assign shadow_hit = on_bridge && (in_win || in_rom);
   assign rel        = off - OFF_W'(WIN_LO);
   assign shadow_idx = rel[IDX_W+1:2];

   assign dwa    = off[OFF_W-1:2];
   assign hdr_dw = on_bridge && (dwa == DWA_W'(HDR_DW));
   assign cls_dw = on_bridge && (dwa == DWA_W'(CLS_DW));

endmodule

// File: rtl/t1_shim_shadow.sv
module t1_shim_shadow
   import t1_shim_pkg::*;
#(
   parameter int                DEPTH     = 11,
   parameter int                IDX_W     = 4,
   parameter int                BUS_W     = 8,
   parameter int                BUS_IDX   = 2,
   parameter int                IO_IDX    = 3,
   parameter int                PREF_IDX  = 5,
   parameter logic [31:0]       IO_INIT   = 32'h0000_0101,
   parameter logic [31:0]       PREF_INIT = 32'h0001_0001,
   parameter logic [DEPTH-1:0]  ZERO_MASK = 11'b110_0000_0011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [LANES-1:0]   wr_be,
   input  logic [DWORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DWORD_W-1:0] rd_data,
   output logic [BUS_W-1:0]   pri_bus,
   output logic [BUS_W-1:0]   sec_bus
);

   initial begin
      assert (BUS_W <= 8) else $error("bus number wider than one byte");
      assert (DEPTH <= (1 << IDX_W)) else $error("index too narrow for depth");
      assert (BUS_IDX < DEPTH) else $error("bus dword outside shadow");
   end

   logic [DEPTH-1:0][DWORD_W-1:0] cell_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [DWORD_W-1:0] INIT = (i == IO_IDX)   ? IO_INIT :
                                            (i == PREF_IDX) ? PREF_INIT : '0;
      if (ZERO_MASK[i]) begin : g_fixed
         assign cell_q[i] = '0;
      end else begin : g_store
         logic [DWORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= INIT;
            else if (wr_en && (wr_idx == IDX_W'(i)))
               q <= lane_merge(q, wr_data, wr_be);
         end
         assign cell_q[i] = q;
      end
   end

   assign rd_data = (int'(rd_idx) < DEPTH) ? cell_q[rd_idx] : '0;

   logic bus_dw_wr;
   assign bus_dw_wr = wr_en && (wr_idx == IDX_W'(BUS_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_bus <= '0;
         sec_bus <= '0;
      end else if (bus_dw_wr) begin
         if (wr_be[0]) pri_bus <= wr_data[BUS_W-1:0];
         if (wr_be[1]) sec_bus <= wr_data[8 +: BUS_W];
      end
   end

   AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pri_bus) |-> $past(bus_dw_wr && wr_be[0])); // R6

   AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sec_bus) |-> $past(bus_dw_wr && wr_be[1])); // R7

endmodule

// File: rtl/t1_shim_rdpath.sv
module t1_shim_rdpath
   import t1_shim_pkg::*;
#(
   parameter bit          CLASS_PATCH = 1'b1,
   parameter logic [23:0] CLASS_CODE  = 24'h060400,
   parameter logic [6:0]  HDR_LAYOUT  = 7'h01
) (
   input  rd_src_e            src,
   input  logic [DWORD_W-1:0] shadow_dw,
   input  logic [DWORD_W-1:0] hw_dw,
   input  logic               hdr_dw,
   input  logic               cls_dw,
   input  logic [1:0]         size,
   input  logic [1:0]         ofs,
   output logic [DWORD_W-1:0] value
);

   logic [DWORD_W-1:0] after_hdr;
   logic [DWORD_W-1:0] after_cls;
   logic [DWORD_W-1:0] full;

   always_comb begin
      after_hdr = hw_dw;
      if (hdr_dw) after_hdr[22:16] = HDR_LAYOUT;
   end

   if (CLASS_PATCH) begin : g_class
      assign after_cls = cls_dw ? {CLASS_CODE, after_hdr[7:0]} : after_hdr;
   end else begin : g_noclass
      assign after_cls = after_hdr;
   end

   always_comb begin
      case (src)
         SRC_SHADOW: full = shadow_dw;
         SRC_FLOAT:  full = '1;
         default:    full = after_cls;
      endcase
   end

   assign value = lane_pick(full, size, ofs);

endmodule

// File: rtl/t1_bridge_shim.sv
module t1_bridge_shim
   import t1_shim_pkg::*;
#(
   parameter int          BUS_W       = 8,
   parameter int          DEV_W       = 5,
   parameter int          FN_W        = 3,
   parameter int          OFF_W       = 12,
   parameter int          LOCAL_DEV   = 1,
   parameter bit          CLASS_PATCH = 1'b1,
   parameter logic [23:0] CLASS_CODE  = 24'h060400,
   parameter logic [6:0]  HDR_LAYOUT  = 7'h01,
   parameter logic [7:0]  IO_TYPE     = 8'h01,
   parameter logic [15:0] PREF_TYPE   = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_func,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              fwd_valid,
   output logic              fwd_write,
   output logic [BUS_W-1:0]  fwd_bus,
   output logic [DEV_W-1:0]  fwd_dev,
   output logic [FN_W-1:0]   fwd_func,
   output logic [OFF_W-1:0]  fwd_offset,
   output logic [3:0]        fwd_be,
   output logic [31:0]       fwd_wdata,
   input  logic [31:0]       fwd_rdata,
   output logic [BUS_W-1:0]  pri_bus,
   output logic [BUS_W-1:0]  sec_bus
);

   localparam int WIN_LO   = 'h10;
   localparam int WIN_HI   = 'h33;
   localparam int ROM_LO   = 'h38;
   localparam int ROM_HI   = 'h3B;
   localparam int DEPTH    = (ROM_LO - WIN_LO) / 4 + 1;
   localparam int IDX_W    = $clog2(DEPTH);
   localparam int BUS_IDX  = ('h18 - WIN_LO) / 4;
   localparam int IO_IDX   = ('h1C - WIN_LO) / 4;
   localparam int PREF_IDX = ('h24 - WIN_LO) / 4;
   localparam logic [DEPTH-1:0] ZERO_MASK = DEPTH'(3) | (DEPTH'(3) << (DEPTH - 2));
   localparam logic [31:0] IO_INIT   = {16'd0, IO_TYPE, IO_TYPE};
   localparam logic [31:0] PREF_INIT = {PREF_TYPE, PREF_TYPE};

   initial begin
      assert (LOCAL_DEV > 0 && LOCAL_DEV < (1 << DEV_W)) else $error("local device out of range");
      assert (OFF_W >= 8) else $error("offset must cover the header");
   end

   logic             on_bridge;
   logic             blocked;
   logic             shadow_hit;
   logic [IDX_W-1:0] shadow_idx;
   logic             hdr_dw;
   logic             cls_dw;
   logic [3:0]       be;
   logic [31:0]      placed;
   logic [31:0]      shadow_dw;
   logic [31:0]      rd_value;
   rd_src_e          src;

   t1_shim_decode #(
      .BUS_W (BUS_W), .DEV_W (DEV_W), .FN_W (FN_W), .OFF_W (OFF_W),
      .IDX_W (IDX_W), .WIN_LO (WIN_LO), .WIN_HI (WIN_HI),
      .ROM_LO (ROM_LO), .ROM_HI (ROM_HI), .HDR_DW (3), .CLS_DW (2)
   ) decode_i (
      .bus        (req_bus),
      .dev        (req_dev),
      .fn         (req_func),
      .off        (req_offset),
      .pri        (pri_bus),
      .on_bridge  (on_bridge),
      .blocked    (blocked),
      .shadow_hit (shadow_hit),
      .shadow_idx (shadow_idx),
      .hdr_dw     (hdr_dw),
      .cls_dw     (cls_dw)
   );

   assign be     = lane_enables(req_size, req_offset[1:0]);
   assign placed = lane_place(req_wdata, req_size, req_offset[1:0]);

   t1_shim_shadow #(
      .DEPTH (DEPTH), .IDX_W (IDX_W), .BUS_W (BUS_W), .BUS_IDX (BUS_IDX),
      .IO_IDX (IO_IDX), .PREF_IDX (PREF_IDX), .IO_INIT (IO_INIT),
      .PREF_INIT (PREF_INIT), .ZERO_MASK (ZERO_MASK)
   ) shadow_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (req_valid && req_write && shadow_hit),
      .wr_idx  (shadow_idx),
      .wr_be   (be),
      .wr_data (placed),
      .rd_idx  (shadow_idx),
      .rd_data (shadow_dw),
      .pri_bus (pri_bus),
      .sec_bus (sec_bus)
   );

   assign fwd_valid  = req_valid && !blocked && !shadow_hit;
   assign fwd_write  = req_write;
   assign fwd_bus    = on_bridge ? sec_bus : req_bus;
   assign fwd_dev    = on_bridge ? DEV_W'(LOCAL_DEV) : req_dev;
   assign fwd_func   = on_bridge ? '0 : req_func;
   assign fwd_offset = {req_offset[OFF_W-1:2], 2'b00};
   assign fwd_be     = be;
   assign fwd_wdata  = placed;

   assign src = shadow_hit ? SRC_SHADOW : (blocked ? SRC_FLOAT : SRC_HW);

   t1_shim_rdpath #(
      .CLASS_PATCH (CLASS_PATCH), .CLASS_CODE (CLASS_CODE), .HDR_LAYOUT (HDR_LAYOUT)
   ) rdpath_i (
      .src       (src),
      .shadow_dw (shadow_dw),
      .hw_dw     (fwd_rdata),
      .hdr_dw    (hdr_dw),
      .cls_dw    (cls_dw),
      .size      (req_size),
      .ofs       (req_offset[1:0]),
      .value     (rd_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write) rsp_rdata <= rd_value;
      end
   end

   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_size != 2'd3) &&
                    !(req_size == 2'd1 && req_offset[0]) &&
                    !(req_size == 2'd2 && req_offset[1:0] != 2'b00)); // R3

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write)); // R12

   AST_BAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(shadow_hit && ZERO_MASK[shadow_idx])) |-> rsp_rdata == '0); // R2

   AST_BLOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(blocked)) |-> rsp_rdata[7:0] == 8'hFF); // R10

   AST_HDR_PATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(hdr_dw && req_size == 2'd2)) |-> rsp_rdata[22:16] == HDR_LAYOUT); // R4

   AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && req_bus == pri_bus) |-> (fwd_bus == sec_bus && fwd_dev == DEV_W'(LOCAL_DEV))); // R9

   AST_SHADOW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus == pri_bus && req_dev == '0 && req_func == '0 &&
       req_offset >= OFF_W'(WIN_LO) && req_offset <= OFF_W'(WIN_HI)) |-> !fwd_valid); // R1

endmodule

// File: tb/t1_bridge_shim_tb.sv
module t1_bridge_shim_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [1:0]  req_size;
   logic [7:0]  req_bus;
   logic [4:0]  req_dev;
   logic [2:0]  req_func;
   logic [11:0] req_offset;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        fwd_valid;
   logic        fwd_write;
   logic [7:0]  fwd_bus;
   logic [4:0]  fwd_dev;
   logic [2:0]  fwd_func;
   logic [11:0] fwd_offset;
   logic [3:0]  fwd_be;
   logic [31:0] fwd_wdata;
   logic [31:0] fwd_rdata;
   logic [7:0]  pri_bus;
   logic [7:0]  sec_bus;

   int n_vec = 0;
   int n_bad = 0;

   logic [31:0] sh [11];
   logic [7:0]  m_pri;
   logic [7:0]  m_sec;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] hw_model(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [11:0] o);
      return {6'h2A, b, d, f, o[11:2]};
   endfunction

   assign fwd_rdata = hw_model(fwd_bus, fwd_dev, fwd_func, fwd_offset);

   t1_bridge_shim dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
      .req_bus (req_bus), .req_dev (req_dev), .req_func (req_func),
      .req_offset (req_offset), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .fwd_valid (fwd_valid), .fwd_write (fwd_write), .fwd_bus (fwd_bus),
      .fwd_dev (fwd_dev), .fwd_func (fwd_func), .fwd_offset (fwd_offset),
      .fwd_be (fwd_be), .fwd_wdata (fwd_wdata), .fwd_rdata (fwd_rdata),
      .pri_bus (pri_bus), .sec_bus (sec_bus)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [3:0] e_be(input logic [1:0] sz, input logic [1:0] o);
      if (sz == 2'd0) return 4'(1 << o);
      if (sz == 2'd1) return o[1] ? 4'hC : 4'h3;
      return 4'hF;
   endfunction

   function automatic logic [31:0] e_place(input logic [31:0] d, input logic [1:0] sz,
                                           input logic [1:0] o);
      if (sz == 2'd0) return (d & 32'hFF) << (8 * o);
      if (sz == 2'd1) return (d & 32'hFFFF) << (16 * o[1]);
      return d;
   endfunction

   function automatic logic [31:0] e_pick(input logic [31:0] d, input logic [1:0] sz,
                                          input logic [1:0] o);
      if (sz == 2'd0) return (d >> (8 * o)) & 32'hFF;
      if (sz == 2'd1) return (d >> (16 * o[1])) & 32'hFFFF;
      return d;
   endfunction

   task automatic acc(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                      input logic [2:0] fn, input logic [11:0] off, input logic [1:0] sz,
                      input logic [31:0] wd, input string rq);
      logic        br, blk, hit, exp_fwd;
      int          idx;
      logic [7:0]  fb;
      logic [4:0]  fd;
      logic [2:0]  ff;
      logic [31:0] dw, pl;
      logic [3:0]  be;
      br  = (bus == m_pri) && dev == 0 && fn == 0;
      blk = (bus == m_pri) && !(dev == 0 && fn == 0);
      hit = br && ((off >= 12'h10 && off <= 12'h33) || (off >= 12'h38 && off <= 12'h3B));
      idx = (int'(off) - 16) / 4;
      exp_fwd = !blk && !hit;
      fb = br ? m_sec : bus;
      fd = br ? 5'd1 : dev;
      ff = br ? 3'd0 : fn;
      be = e_be(sz, off[1:0]);
      pl = e_place(wd, sz, off[1:0]);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_bus = bus;
      req_dev = dev; req_func = fn; req_offset = off; req_wdata = wd;
      #(CLK_PERIOD/4);
      chk(rq, "fwd_valid", 32'(fwd_valid), 32'(exp_fwd));
      if (exp_fwd) begin
         chk(rq, "fwd_bus",    32'(fwd_bus),    32'(fb));
         chk(rq, "fwd_dev",    32'(fwd_dev),    32'(fd));
         chk(rq, "fwd_func",   32'(fwd_func),   32'(ff));
         chk(rq, "fwd_offset", 32'(fwd_offset), 32'({off[11:2], 2'b00}));
         chk(rq, "fwd_write",  32'(fwd_write),  32'(wr));
         if (wr) begin
            chk(rq, "fwd_be",    32'(fwd_be), 32'(be));
            chk(rq, "fwd_wdata", fwd_wdata,   pl);
         end
      end
      if (hit)      dw = sh[idx];
      else if (blk) dw = 32'hFFFF_FFFF;
      else begin
         dw = hw_model(fb, fd, ff, off);
         if (br && off[11:2] == 10'd3) dw[22:16] = 7'h01;
         if (br && off[11:2] == 10'd2) dw[31:8]  = 24'h060400;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         chk(rq, "rsp_valid", 32'(rsp_valid), 32'd1);
         chk(rq, "rsp_rdata", rsp_rdata, e_pick(dw, sz, off[1:0]));
      end else begin
         chk("R12", "rsp_valid after write", 32'(rsp_valid), 32'd0);
         if (hit) begin
            if (idx == 0 || idx == 1 || idx == 10) sh[idx] = 32'd0;
            else for (int i = 0; i < 4; i++) if (be[i]) sh[idx][i*8 +: 8] = pl[i*8 +: 8];
            if (idx == 2 && be[0]) m_pri = pl[7:0];
            if (idx == 2 && be[1]) m_sec = pl[15:8];
         end
      end
      chk(rq, "pri_bus", 32'(pri_bus), 32'(m_pri));
      chk(rq, "sec_bus", 32'(sec_bus), 32'(m_sec));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 11; i++) sh[i] = 32'd0;
      sh[3] = 32'h0000_0101;
      sh[5] = 32'h0001_0001;
      m_pri = 8'd0; m_sec = 8'd0;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
      req_bus = '0; req_dev = '0; req_func = '0; req_offset = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "pri_bus reset", 32'(pri_bus), 32'd0);
      chk("R8", "sec_bus reset", 32'(sec_bus), 32'd0);
      chk("R12", "rsp_valid idle", 32'(rsp_valid), 32'd0);

      // R8 / R1: reset contents of every shadow dword, plus neighbours that are forwarded
      for (int o = 'h10; o <= 'h3C; o += 4) acc(0, 8'd0, 5'd0, 3'd0, 12'(o), 2'd2, 0, "R8");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h110, 2'd2, 0, "R1");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h034, 2'd1, 0, "R1");

      // R2 / R3: word patterns to all shadow dwords except bus numbers
      for (int o = 'h10; o <= 'h38; o += 4)
         if (o != 'h18 && o != 'h34) begin
            acc(1, 8'd0, 5'd0, 3'd0, 12'(o), 2'd2, 32'hC3A5_0000 | 32'(o), "R2");
            acc(0, 8'd0, 5'd0, 3'd0, 12'(o), 2'd2, 0, "R2");
         end

      // R3: byte and half merges with lane reads
      for (int b = 0; b < 4; b++)
         acc(1, 8'd0, 5'd0, 3'd0, 12'(16'h1C + b), 2'd0, 32'(8'h10 + b * 8'h11), "R3");
      for (int b = 0; b < 4; b++)
         acc(0, 8'd0, 5'd0, 3'd0, 12'(16'h1C + b), 2'd0, 0, "R3");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h020, 2'd1, 32'hFFFF_BEEF, "R3");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h022, 2'd1, 32'h0000_1234, "R3");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h020, 2'd1, 0, "R3");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h022, 2'd1, 0, "R3");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h020, 2'd2, 0, "R3");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h039, 2'd0, 32'h77, "R2");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h038, 2'd2, 0, "R2");

      // R7 / R6: bus number capture variants
      acc(1, 8'd0, 5'd0, 3'd0, 12'h019, 2'd0, 32'h25, "R7");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd1, 32'h2600, "R7");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0030_2700, "R7");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h01A, 2'd0, 32'h40, "R7");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h01A, 2'd1, 32'h5566, "R7");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 0, "R7");

      // R4 / R5 / R9: redirected bridge reads and writes, secondary 0x27
      for (int b = 0; b < 4; b++) acc(0, 8'd0, 5'd0, 3'd0, 12'(16'h0C + b), 2'd0, 0, "R4");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h00C, 2'd2, 0, "R4");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h00E, 2'd1, 0, "R4");
      for (int b = 0; b < 4; b++) acc(0, 8'd0, 5'd0, 3'd0, 12'(16'h08 + b), 2'd0, 0, "R5");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h008, 2'd2, 0, "R5");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h00A, 2'd1, 0, "R5");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h000, 2'd2, 0, "R9");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h004, 2'd1, 32'h0000_0146, "R9");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h03D, 2'd0, 32'h0000_00AB, "R9");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h3FC, 2'd2, 0, "R9");
      acc(1, 8'd0, 5'd0, 3'd0, 12'h019, 2'd0, 32'h05, "R7");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h00C, 2'd2, 0, "R4");

      // R10: every other device/function on the primary bus
      for (int d = 0; d < 32; d++)
         for (int f = 0; f < 8; f++)
            if (d != 0 || f != 0) begin
               acc(0, 8'd0, 5'(d), 3'(f), 12'(4 * f), 2'(f % 3), 0, "R10");
               if (f == 3) acc(1, 8'd0, 5'(d), 3'(f), 12'h010, 2'd2, 32'h1234_5678, "R10");
            end

      // R11: other buses pass unchanged
      for (int d = 0; d < 32; d++) begin
         acc(0, 8'h05, 5'(d), 3'(d % 8), 12'(8 * d + 2), 2'd1, 0, "R11");
         acc(1, 8'hFF, 5'(d), 3'((d + 3) % 8), 12'(8 * d + 1), 2'd0, 32'(d * 7 + 1), "R11");
         acc(1, 8'h27, 5'(d), 3'd0, 12'(4 * d), 2'd2, 32'hA000_0000 + 32'(d), "R11");
      end

      // R6: moving the primary bus moves the bridge
      acc(1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd0, 32'h03, "R6");
      acc(0, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 0, "R6");
      acc(0, 8'd3, 5'd0, 3'd0, 12'h018, 2'd2, 0, "R6");
      acc(0, 8'd3, 5'd0, 3'd0, 12'h01C, 2'd2, 0, "R6");
      acc(0, 8'd3, 5'd2, 3'd0, 12'h000, 2'd2, 0, "R10");
      acc(0, 8'd3, 5'd0, 3'd0, 12'h00C, 2'd2, 0, "R4");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule